// File: doc/BRIEF.md
# Packed-Lane Immediate Left Shifter

This block shifts every integer lane of a 64-bit or 128-bit operand left by one common amount. Lanes and shift amount are both taken from a single 7-bit control word. The position of the highest set bit in that word picks the lane width (8, 16, 32 or 64 bits). The bits below that leading one give the shift count. Bits pushed past the top of a lane are lost, zeros fill in from the bottom, and nothing leaks into the neighbouring lane. Signed and unsigned data are treated alike.

A quad select widens the operation from one 64-bit half to two halves, both using the same lane setup. The block also reports two conditions:
- an illegal register pairing in quad mode, flagged as undefined;
- a control word with no leading one among its top four bits, flagged as reserved.

Work passes through one register stage with a valid/ready handshake on each side. A result may wait at the output under back-pressure. A new operand is taken only when the output slot is empty or is being drained in the same cycle. Timing never depends on the data.

Top module: `packed_lane_shl`

## Requirements
- R1: When ctrl[6:3] = 0001, the lanes are 8 bits wide (eight per half) and each lane shifts by ctrl[2:0].
- R2: When ctrl[6:4] = 001, the lanes are 16 bits wide (four per half) and each lane shifts by ctrl[3:0].
- R3: When ctrl[6:5] = 01, the lanes are 32 bits wide (two per half) and each lane shifts by ctrl[4:0].
- R4: When ctrl[6] = 1, each half is one 64-bit lane and shifts by ctrl[5:0].
- R5: Bits leaving the top of a lane are dropped and zeros enter at its bottom. No bit moves from one lane into another.
- R6: When ctrl[6:3] = 0000, out_rsvd is 1 and the low 64 result bits equal the low 64 operand bits unchanged. In quad mode the upper 64 bits are also passed through unchanged.
- R7: When in_quad = 1 and in_dst_lsb or in_src_lsb is 1, out_undef is 1 and the whole result is zero. This overrides every other rule, while out_rsvd still reports the control word.
- R8: When in_quad = 0, result bits [127:64] are zero. When in_quad = 1, operand bits [127:64] are processed with the same lane setup as the lower half.
- R9: An input is accepted on a clock edge where in_valid and in_ready are both 1. in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid = 1 and out_ready = 0, out_valid and all output data and flags hold steady.
- R10: After reset, out_valid, out_data, out_undef and out_rsvd are 0 and in_ready is 1.
- R11: Every accepted input shows up on the outputs with out_valid = 1 exactly one clock after acceptance, whatever the operand and control values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_data | input | 128 | Operand; the lower 64 bits form half 0 |
| in_ctrl | input | 7 | Leading-one coded lane size and shift amount |
| in_quad | input | 1 | 1 = process both 64-bit halves |
| in_dst_lsb | input | 1 | LSB of the destination register index |
| in_src_lsb | input | 1 | LSB of the source register index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Shifted result |
| out_undef | output | 1 | Illegal quad register pairing |
| out_rsvd | output | 1 | Control word is a reserved pattern |

## Verification
The bench targets the largest shift for each lane width: 7, 15, 31 and 63. A design with a bad lane mask would there either let high bits spill into the next lane or leave stale low bits in place. It checks shift zero and the reserved pattern, where a broken decoder would show as an off-by-size shift or a missing pass-through. It also checks quad requests with odd register indices, where a wrong override would leak shifted data past the undefined flag, and non-quad requests whose upper operand half is loaded with ones, which a design must not let through. A randomised phase with a stalling consumer shows whether results are lost, duplicated or altered while they wait.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int HALF_W = 64;
  localparam int CTRL_W = 7;
  localparam int SH_W   = $clog2(HALF_W);

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sz_e;

  typedef struct packed {
    lane_sz_e          sz;
    logic [SH_W-1:0]   sh;
    logic              rsvd;
  } shl_cfg_t;
endpackage

// File: rtl/pls_decode.sv
module pls_decode
  import pls_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output shl_cfg_t          cfg
);
  always_comb begin
    cfg = '0;
    casez (ctrl)
      7'b1??????: begin cfg.sz = LANE_64; cfg.sh = ctrl[5:0]; end
      7'b01?????: begin cfg.sz = LANE_32; cfg.sh = {1'b0, ctrl[4:0]}; end
      7'b001????: begin cfg.sz = LANE_16; cfg.sh = {2'b0, ctrl[3:0]}; end
      7'b0001???: begin cfg.sz = LANE_8;  cfg.sh = {3'b0, ctrl[2:0]}; end
      default: begin
        // reserved pattern: a zero shift on one wide lane passes the operand through
        cfg.sz   = LANE_64;
        cfg.sh   = '0;
        cfg.rsvd = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pls_half.sv
module pls_half
  import pls_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic [W-1:0] din,
  input  shl_cfg_t     cfg,
  output logic [W-1:0] dout
);
  localparam int SW = $clog2(W);

  // logarithmic shifter: one mux level per shift bit, same depth for all inputs
  logic [W-1:0] stage [SW+1];
  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stage[k+1] = cfg.sh[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  // offset of a bit inside its lane, masked by lane width minus one
  logic [SW-1:0] pos_mask;
  always_comb begin
    unique case (cfg.sz)
      LANE_8:  pos_mask = SW'(7);
      LANE_16: pos_mask = SW'(15);
      LANE_32: pos_mask = SW'(31);
      default: pos_mask = SW'(W - 1);
    endcase
  end

  // a bit survives only if its in-lane offset is at least the shift amount;
  // lower bits would have come from the lane below
  logic [W-1:0] keep;
  for (genvar i = 0; i < W; i++) begin : g_keep
    localparam logic [SW-1:0] POS = SW'(i);
    assign keep[i] = ((POS & pos_mask) >= cfg.sh[SW-1:0]);
  end

  assign dout = stage[SW] & keep;
endmodule

// File: rtl/packed_lane_shl.sv
module packed_lane_shl
  import pls_pkg::*;
#(
  parameter int NHALF = 2,
  localparam int DW   = NHALF * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_quad,
  input  logic              in_dst_lsb,
  input  logic              in_src_lsb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_undef,
  output logic              out_rsvd
);
  shl_cfg_t cfg;

  pls_decode u_dec (
    .ctrl (in_ctrl),
    .cfg  (cfg)
  );

  logic [DW-1:0] shl_res;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] hout;
    pls_half #(.W(HALF_W)) u_half (
      .din  (in_data[h*HALF_W +: HALF_W]),
      .cfg  (cfg),
      .dout (hout)
    );
    if (h == 0) begin : g_lo
      assign shl_res[h*HALF_W +: HALF_W] = hout;
    end else begin : g_hi
      assign shl_res[h*HALF_W +: HALF_W] = in_quad ? hout : '0;
    end
  end

  logic undef_c;
  assign undef_c = in_quad & (in_dst_lsb | in_src_lsb);

  logic accept;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_undef <= 1'b0;
      out_rsvd  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= undef_c ? '0 : shl_res;
      out_undef <= undef_c;
      out_rsvd  <= cfg.rsvd;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/packed_lane_shl_chk.sv
module packed_lane_shl_chk
  import pls_pkg::*;
#(
  parameter int DW = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DW-1:0]     in_data,
  input logic [CTRL_W-1:0] in_ctrl,
  input logic              in_quad,
  input logic              in_dst_lsb,
  input logic              in_src_lsb,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_data,
  input logic              out_undef,
  input logic              out_rsvd
);
  logic acc_ok;
  assign acc_ok = in_valid && in_ready && !(in_quad && (in_dst_lsb || in_src_lsb));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                 && $stable(out_undef) && $stable(out_rsvd));

  a_r11_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_data == '0);

  a_r7_undef_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_quad && (in_dst_lsb || in_src_lsb) |=> out_undef);

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_quad |=> out_data[DW-1:HALF_W] == '0);

  a_r6_rsvd_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && in_ctrl[6:3] == 4'b0000
    |=> out_rsvd && out_data[HALF_W-1:0] == $past(in_data[HALF_W-1:0]));

  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && in_ctrl[6:3] != 4'b0000 && in_ctrl[2:0] != 3'b000
    |=> out_data[0] == 1'b0);
endmodule

bind packed_lane_shl packed_lane_shl_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_ctrl    (in_ctrl),
  .in_quad    (in_quad),
  .in_dst_lsb (in_dst_lsb),
  .in_src_lsb (in_src_lsb),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_undef  (out_undef),
  .out_rsvd   (out_rsvd)
);

// File: tb/packed_lane_shl_tb.sv
module packed_lane_shl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [6:0]   in_ctrl = '0;
  logic         in_quad = 1'b0;
  logic         in_dst_lsb = 1'b0;
  logic         in_src_lsb = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_undef;
  logic         out_rsvd;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit bp = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  packed_lane_shl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_quad(in_quad),
    .in_dst_lsb(in_dst_lsb), .in_src_lsb(in_src_lsb), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_undef(out_undef),
    .out_rsvd(out_rsvd)
  );

  typedef struct {
    logic [127:0] d;
    logic         u;
    logic         r;
    int           acc;
    string        req;
  } item_t;

  item_t sb[$];

  function automatic void model(input logic [127:0] d, input logic [6:0] c,
                                input logic q, input logic ds, input logic ss,
                                output item_t it);
    int w;
    int sh;
    logic [63:0] m;
    it.r = 1'b0;
    casez (c)
      7'b1??????: begin w = 64; sh = int'(c[5:0]); end
      7'b01?????: begin w = 32; sh = int'(c[4:0]); end
      7'b001????: begin w = 16; sh = int'(c[3:0]); end
      7'b0001???: begin w = 8;  sh = int'(c[2:0]); end
      default:    begin w = 64; sh = 0; it.r = 1'b1; end
    endcase
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    it.d = '0;
    for (int h = 0; h < 2; h++) begin
      if (h == 0 || q) begin
        logic [63:0] src;
        logic [63:0] res;
        src = d[h*64 +: 64];
        res = '0;
        for (int l = 0; l < 64 / w; l++) begin
          logic [63:0] lane;
          lane = (src >> (l * w)) & m;
          res  = res | (((lane << sh) & m) << (l * w));
        end
        it.d[h*64 +: 64] = res;
      end
    end
    it.u = q && (ds || ss);
    if (it.u) it.d = '0;
    if (it.u)        it.req = "R7";
    else if (it.r)   it.req = "R6/R8";
    else if (w == 8)  it.req = "R1/R5/R8";
    else if (w == 16) it.req = "R2/R5/R8";
    else if (w == 32) it.req = "R3/R5/R8";
    else              it.req = "R4/R5/R8";
  endfunction

  task automatic send(input logic [127:0] d, input logic [6:0] c,
                      input logic q, input logic ds, input logic ss);
    item_t it;
    model(d, c, q, ds, ss, it);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_ctrl = c;
    in_quad = q; in_dst_lsb = ds; in_src_lsb = ss;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    it.acc = cyc;
    sb.push_back(it);
  endtask

  task automatic idle_wait();
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
  endtask

  // consumer: steady or randomly stalling
  initial forever begin
    @(posedge clk); #1;
    out_ready = bp ? ($urandom % 4 != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit           front_seen = 1'b0;
  bit           stall_d = 1'b0;
  logic [127:0] held;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (stall_d) begin
        total++;
        if (!(out_valid && out_data == held)) begin
          bad++;
          $display("FAIL R9 stalled output changed: valid=%0b data=%h expected %h",
                   out_valid, out_data, held);
        end
      end
      stall_d = out_valid && !out_ready;
      held = out_data;
      if (out_valid) begin
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 output valid with no pending item: data=%h expected none", out_data);
        end else begin
          if (!front_seen) begin
            total++;
            if (cyc != sb[0].acc + 1) begin
              bad++;
              $display("FAIL R11 latency: seen at %0d expected %0d", cyc, sb[0].acc + 1);
            end
            front_seen = 1'b1;
          end
          if (out_ready) begin
            item_t e;
            e = sb.pop_front();
            total++;
            if (out_data !== e.d || out_undef !== e.u || out_rsvd !== e.r) begin
              bad++;
              $display("FAIL %s: data=%h undef=%0b rsvd=%0b expected data=%h undef=%0b rsvd=%0b",
                       e.req, out_data, out_undef, out_rsvd, e.d, e.u, e.r);
            end
            front_seen = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [127:0] ONES = '1;
  localparam logic [127:0] ALT  = {4{32'hA5C3_9F10}};
  localparam logic [127:0] SEQ  = 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;  // R10 reset state
    if (out_valid !== 1'b0 || out_data !== '0 || out_undef !== 1'b0 ||
        out_rsvd !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R10 reset: valid=%0b data=%h undef=%0b rsvd=%0b ready=%0b expected 0/0/0/0/1",
               out_valid, out_data, out_undef, out_rsvd, in_ready);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    // R1 eight-bit lanes: shifts 0, 3, 7
    send(ONES, 7'b0001000, 1'b1, 1'b0, 1'b0);
    send(ALT,  7'b0001011, 1'b1, 1'b0, 1'b0);
    send(ONES, 7'b0001111, 1'b1, 1'b0, 1'b0);
    // R2 sixteen-bit lanes
    send(SEQ,  7'b0010101, 1'b1, 1'b0, 1'b0);
    send(ONES, 7'b0011111, 1'b1, 1'b0, 1'b0);
    // R3 thirty-two-bit lanes
    send(SEQ,  7'b0100000, 1'b1, 1'b0, 1'b0);
    send(ONES, 7'b0111111, 1'b1, 1'b0, 1'b0);
    // R4 one wide lane
    send(SEQ,  7'b1000000, 1'b1, 1'b0, 1'b0);
    send(ONES, 7'b1111111, 1'b1, 1'b0, 1'b0);
    send(ALT,  7'b1000100, 1'b1, 1'b0, 1'b0);
    // R6 reserved patterns, quad and single
    send(SEQ,  7'b0000101, 1'b1, 1'b0, 1'b0);
    send(ONES, 7'b0000000, 1'b0, 1'b0, 1'b0);
    // R7 undefined pairing: destination, source, both; with reserved too
    send(ONES, 7'b0001011, 1'b1, 1'b1, 1'b0);
    send(SEQ,  7'b1000001, 1'b1, 1'b0, 1'b1);
    send(ALT,  7'b0000011, 1'b1, 1'b1, 1'b1);
    // R8 single mode with odd indices (no undef) and loaded upper half
    send(ONES, 7'b0010011, 1'b0, 1'b1, 1'b1);
    send(SEQ,  7'b0101010, 1'b0, 1'b0, 1'b0);
    idle_wait();

    // R9/R11 stalling consumer with random traffic
    bp = 1'b1;
    for (int n = 0; n < 120; n++) begin
      logic [127:0] d;
      logic [6:0]   c;
      d = {$urandom, $urandom, $urandom, $urandom};
      c = 7'($urandom);
      send(d, c, 1'($urandom), ($urandom % 8 == 0), ($urandom % 8 == 0));
    end
    idle_wait();
    bp = 1'b0;
    idle_wait();

    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 lost results: pending=%0d expected 0", sb.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule